// File: doc/BRIEF.md
# Text-Mode Line Fetch Sequencer

This block schedules video memory accesses for a single display line. A line is divided into 172 access windows, one per clock. On a text line the block reads a tile name and then that tile's pattern byte for each of 40 columns. Every window that does not carry a display read is handed to the host port as an external slot. On a refresh line, which is used outside the active area, the block alternates refresh windows with host slots instead.

The row number, both table bases and the line type are captured once per line, at the clock edge that closes window 0. Addresses come from masked bases, so a table base can only select aligned regions. Read data is expected one window after each read strobe. The block passes each returned byte to an external line buffer through a write port that carries the column index and a name/pattern select. A one-cycle pulse marks the start of every line after the first.

Top module: `text_fetch_seq`

## Requirements
- R1: While reset is held, the block sits in window 0: host_grant is 1, and mem_rd, refresh_win, lb_we and line_done are all 0.
- R2: On a text line, windows 0 through 46 are host slots with no memory read.
- R3: On a text line, column c (0..39) has a name read in window 47+3c, a host slot in window 48+3c and a pattern read in window 49+3c.
- R4: On a text line, windows 167 through 171 are host slots.
- R5: The name read address for column c is (name_base AND (0x3C00 OR (row/8)*40)) + c, taken modulo 2^14.
- R6: The pattern read address for column c is (patt_base AND (0x3800 OR row mod 8)) + 8*N, modulo 2^14. N is the byte returned for that column's name read.
- R7: In the window after each read, lb_we is 1 and lb_data equals mem_rdata. lb_col is that read's column, and lb_sel_pattern is 0 after a name read and 1 after a pattern read. In every other window lb_we is 0.
- R8: On a refresh line (refresh_mode=1), windows 0 through 43 are host slots. From window 44 on, even offsets from 44 are refresh windows and odd offsets are host slots. No memory reads occur on a refresh line.
- R9: refresh_mode, row, name_base and patt_base are sampled only at the edge that ends window 0. Changes at any other time have no effect on that line.
- R10: line_done is high for exactly one cycle: the window 0 that follows window 171. The line period is 172 cycles.
- R11: In every window exactly one of host_grant, mem_rd and refresh_win is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Window clock, one access window per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_mode | input | 1 | 1 selects the refresh-line schedule for the next line |
| row | input | 8 | Display row of the next line |
| name_base | input | 14 | Name table base address |
| patt_base | input | 14 | Pattern generator base address |
| mem_rdata | input | 8 | Read data, valid in the window after mem_rd |
| mem_addr | output | 14 | Read address while mem_rd is high, zero otherwise |
| mem_rd | output | 1 | Display read in this window |
| host_grant | output | 1 | Window belongs to the host port |
| refresh_win | output | 1 | Refresh window |
| lb_we | output | 1 | Line buffer write strobe |
| lb_sel_pattern | output | 1 | 0 writes the name field, 1 writes the pattern field |
| lb_col | output | 6 | Line buffer column index |
| lb_data | output | 8 | Line buffer write data |
| line_done | output | 1 | One-cycle pulse at the start of each new line |

## Verification
A window counter that is off by even one shifts the whole column schedule. This appears within one window as a host grant where a read was expected, or as a read one slot early. A stale column or phase counter puts the wrong column on lb_col, or forms the pattern address from the previous column's name, and is seen at the first write that follows. A slip in the per-line latch only appears when the inputs are changed in the middle of a line. The bench changes them mid-line every line, so such an error shows up in the next read address.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

  localparam int TFS_AW = 14;

  typedef enum logic [1:0] {
    SLOT_HOST = 2'd0,
    SLOT_NAME = 2'd1,
    SLOT_PATT = 2'd2,
    SLOT_RFSH = 2'd3
  } tfs_slot_e;

  // Name fetch address: masked base plus the column.
  function automatic logic [TFS_AW-1:0] name_addr(
    input logic [TFS_AW-1:0] nbase,
    input logic [7:0]        r,
    input logic [TFS_AW-1:0] col
  );
    logic [TFS_AW-1:0] row_off;
    logic [TFS_AW-1:0] mask;
    row_off = TFS_AW'(r[7:3]) * TFS_AW'(40);
    mask    = 14'h3C00 | row_off;
    return (nbase & mask) + col;
  endfunction

  // Pattern fetch address: masked base plus name times eight.
  function automatic logic [TFS_AW-1:0] patt_addr(
    input logic [TFS_AW-1:0] pbase,
    input logic [7:0]        r,
    input logic [7:0]        nm
  );
    logic [TFS_AW-1:0] mask;
    mask = {3'b111, 8'h00, r[2:0]};
    return (pbase & mask) + {3'b000, nm, 3'b000};
  endfunction

endpackage

// File: rtl/tfs_window_ctr.sv
module tfs_window_ctr #(
  parameter int LINE_WINDOWS = 172,
  localparam int WIN_W = $clog2(LINE_WINDOWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIN_W-1:0] win,
  output logic             done
);
  localparam logic [WIN_W-1:0] LAST = WIN_W'(LINE_WINDOWS - 1);

  logic at_last;
  assign at_last = (win == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win  <= '0;
      done <= 1'b0;
    end else begin
      win  <= at_last ? '0 : win + 1'b1;
      done <= at_last;
    end
  end
endmodule

// File: rtl/tfs_slot_decode.sv
module tfs_slot_decode
  import tfs_pkg::*;
#(
  parameter int COLS         = 40,
  parameter int LINE_WINDOWS = 172,
  parameter int TEXT_LEAD    = 47,
  parameter int RFSH_LEAD    = 44,
  localparam int WIN_W = $clog2(LINE_WINDOWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win,
  input  logic             rfsh_line,
  output tfs_slot_e        kind,
  output logic [COL_W-1:0] col
);
  localparam int COL_END = TEXT_LEAD + 3 * COLS;

  logic [1:0] phase_q;
  logic [COL_W-1:0] col_q;
  logic in_cols;
  logic [WIN_W-1:0] rel;

  assign in_cols = (win >= WIN_W'(TEXT_LEAD)) && (win < WIN_W'(COL_END));
  assign rel     = win - WIN_W'(RFSH_LEAD);
  assign col     = col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      col_q   <= '0;
    end else if (win == WIN_W'(TEXT_LEAD - 1)) begin
      phase_q <= 2'd0;
      col_q   <= '0;
    end else if (in_cols) begin
      if (phase_q == 2'd2) begin
        phase_q <= 2'd0;
        col_q   <= col_q + 1'b1;
      end else begin
        phase_q <= phase_q + 2'd1;
      end
    end
  end

  always_comb begin
    kind = SLOT_HOST;
    if (rfsh_line) begin
      if (win >= WIN_W'(RFSH_LEAD) && !rel[0]) kind = SLOT_RFSH;
    end else if (in_cols) begin
      case (phase_q)
        2'd0:    kind = SLOT_NAME;
        2'd2:    kind = SLOT_PATT;
        default: kind = SLOT_HOST;
      endcase
    end
  end
endmodule

// File: rtl/tfs_addr_gen.sv
module tfs_addr_gen
  import tfs_pkg::*;
#(
  parameter int COLS = 40,
  localparam int COL_W = $clog2(COLS)
) (
  input  tfs_slot_e         kind,
  input  logic [COL_W-1:0]  col,
  input  logic [7:0]        row_l,
  input  logic [TFS_AW-1:0] nbase_l,
  input  logic [TFS_AW-1:0] pbase_l,
  input  logic [7:0]        name_q,
  output logic [TFS_AW-1:0] addr,
  output logic              rd
);
  always_comb begin
    addr = '0;
    rd   = 1'b0;
    case (kind)
      SLOT_NAME: begin
        addr = name_addr(nbase_l, row_l, TFS_AW'(col));
        rd   = 1'b1;
      end
      SLOT_PATT: begin
        addr = patt_addr(pbase_l, row_l, name_q);
        rd   = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/text_fetch_seq.sv
module text_fetch_seq
  import tfs_pkg::*;
#(
  parameter int COLS         = 40,
  parameter int LINE_WINDOWS = 172,
  parameter int TEXT_LEAD    = 47,
  parameter int RFSH_LEAD    = 44,
  localparam int WIN_W = $clog2(LINE_WINDOWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              refresh_mode,
  input  logic [7:0]        row,
  input  logic [TFS_AW-1:0] name_base,
  input  logic [TFS_AW-1:0] patt_base,
  input  logic [7:0]        mem_rdata,
  output logic [TFS_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              host_grant,
  output logic              refresh_win,
  output logic              lb_we,
  output logic              lb_sel_pattern,
  output logic [COL_W-1:0]  lb_col,
  output logic [7:0]        lb_data,
  output logic              line_done
);
  logic [WIN_W-1:0]  win_q;
  tfs_slot_e         slot_kind;
  logic [COL_W-1:0]  slot_col;
  logic              mode_l;
  logic [7:0]        row_l;
  logic [TFS_AW-1:0] nbase_l;
  logic [TFS_AW-1:0] pbase_l;
  tfs_slot_e         prev_kind_q;
  logic [COL_W-1:0]  prev_col_q;
  logic [7:0]        name_q;

  tfs_window_ctr #(.LINE_WINDOWS(LINE_WINDOWS)) u_win (
    .clk(clk), .rst_n(rst_n), .win(win_q), .done(line_done)
  );

  tfs_slot_decode #(
    .COLS(COLS), .LINE_WINDOWS(LINE_WINDOWS),
    .TEXT_LEAD(TEXT_LEAD), .RFSH_LEAD(RFSH_LEAD)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .win(win_q), .rfsh_line(mode_l),
    .kind(slot_kind), .col(slot_col)
  );

  tfs_addr_gen #(.COLS(COLS)) u_addr (
    .kind(slot_kind), .col(slot_col), .row_l(row_l),
    .nbase_l(nbase_l), .pbase_l(pbase_l), .name_q(name_q),
    .addr(mem_addr), .rd(mem_rd)
  );

  // Per-line configuration, captured as window 0 closes.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_l  <= 1'b0;
      row_l   <= '0;
      nbase_l <= '0;
      pbase_l <= '0;
    end else if (win_q == '0) begin
      mode_l  <= refresh_mode;
      row_l   <= row;
      nbase_l <= name_base;
      pbase_l <= patt_base;
    end
  end

  // Read-return tracking: data arrives one window after the strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_kind_q <= SLOT_HOST;
      prev_col_q  <= '0;
      name_q      <= '0;
    end else begin
      prev_kind_q <= slot_kind;
      prev_col_q  <= slot_col;
      if (prev_kind_q == SLOT_NAME) name_q <= mem_rdata;
    end
  end

  assign host_grant     = (slot_kind == SLOT_HOST);
  assign refresh_win    = (slot_kind == SLOT_RFSH);
  assign lb_we          = (prev_kind_q == SLOT_NAME) || (prev_kind_q == SLOT_PATT);
  assign lb_sel_pattern = (prev_kind_q == SLOT_PATT);
  assign lb_col         = prev_col_q;
  assign lb_data        = mem_rdata;
endmodule

// File: rtl/tfs_checker.sv
module tfs_checker
  import tfs_pkg::*;
#(
  parameter int WIN_W     = 8,
  parameter int LAST      = 171,
  parameter int COL_END   = 167,
  parameter int RFSH_LEAD = 44
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIN_W-1:0] win_q,
  input tfs_slot_e        slot_kind,
  input logic             mode_l,
  input logic             mem_rd,
  input logic             host_grant,
  input logic             refresh_win,
  input logic             lb_we,
  input logic             line_done
);
  // R11
  one_slot_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({host_grant, mem_rd, refresh_win}) == 1);

  // R3
  name_then_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind == SLOT_NAME) |=> host_grant);

  // R3
  patt_after_name_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_kind == SLOT_PATT) |-> $past(slot_kind == SLOT_NAME, 2));

  // R7
  write_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> lb_we);

  // R7
  no_write_without_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> !lb_we);

  // R2
  head_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q < WIN_W'(RFSH_LEAD)) |-> host_grant);

  // R4
  tail_host_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_l && win_q >= WIN_W'(COL_END)) |-> host_grant);

  // R8
  refresh_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_win |=> host_grant);

  // R8
  refresh_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_l |-> !mem_rd);

  // R10
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (win_q == '0));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R10
  done_on_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q == WIN_W'(LAST)) |=> line_done);
endmodule

bind text_fetch_seq tfs_checker #(
  .WIN_W(WIN_W), .LAST(LINE_WINDOWS - 1),
  .COL_END(TEXT_LEAD + 3 * COLS), .RFSH_LEAD(RFSH_LEAD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_q(win_q), .slot_kind(slot_kind),
  .mode_l(mode_l), .mem_rd(mem_rd), .host_grant(host_grant),
  .refresh_win(refresh_win), .lb_we(lb_we), .line_done(line_done)
);

// File: tb/tb_text_fetch_seq.sv
`timescale 1ns/1ps
module tb_text_fetch_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        refresh_mode;
  logic [7:0]  row;
  logic [13:0] name_base, patt_base;
  logic [7:0]  mem_rdata = 8'h00;
  logic [13:0] mem_addr;
  logic        mem_rd, host_grant, refresh_win;
  logic        lb_we, lb_sel_pattern, line_done;
  logic [5:0]  lb_col;
  logic [7:0]  lb_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  text_fetch_seq dut (
    .clk(clk), .rst_n(rst_n), .refresh_mode(refresh_mode), .row(row),
    .name_base(name_base), .patt_base(patt_base), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .host_grant(host_grant),
    .refresh_win(refresh_win), .lb_we(lb_we), .lb_sel_pattern(lb_sel_pattern),
    .lb_col(lb_col), .lb_data(lb_data), .line_done(line_done)
  );

  typedef struct {
    bit g, rd, rf, we, fld, done;
    int addr, idx, data, sreq, areq;
  } exp_t;
  exp_t q[$];

  localparam int NL = 6;
  int cfg_rf  [NL] = '{0, 1, 0, 0, 1, 0};
  int cfg_row [NL] = '{0, 5, 191, 77, 100, 13};
  int cfg_nb  [NL] = '{16'h3FFF, 16'h1234, 16'h2A55, 16'h3FFF, 16'h0000, 16'h0000};
  int cfg_pb  [NL] = '{16'h3FFF, 16'h0000, 16'h1FFF, 16'h2C05, 16'h3FFF, 16'h0000};

  function automatic int mem_val(int a);
    return ((a & 255) ^ ((a >> 8) | 128)) & 255;
  endfunction

  function automatic string tag(int code);
    case (code)
      2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   8: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(bit ok, string t, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, expv);
    end
  endtask

  task automatic apply_cfg(int l);
    refresh_mode = cfg_rf[l][0];
    row          = 8'(cfg_row[l]);
    name_base    = 14'(cfg_nb[l]);
    patt_base    = 14'(cfg_pb[l]);
  endtask

  // Driver side: expected window items for one line, built from the requirements.
  task automatic push_line(int l, bit not_first);
    bit prd = 0, pfld = 0;
    int pcol = 0, paddr = 0, nm = 0;
    int r = cfg_row[l];
    for (int w = 0; w < 172; w++) begin
      exp_t e;
      e = '{default: 0};
      e.done = (w == 0) && not_first;
      if (cfg_rf[l] != 0) begin
        e.sreq = 8;
        if (w >= 44 && ((w - 44) % 2) == 0) e.rf = 1; else e.g = 1;
      end else if (w < 47) begin
        e.sreq = 2; e.g = 1;
      end else if (w >= 167) begin
        e.sreq = 4; e.g = 1;
      end else begin
        int c = (w - 47) / 3;
        int p = (w - 47) % 3;
        e.sreq = 3;
        e.idx = c;
        if (p == 0) begin
          e.rd = 1; e.areq = (w > 80) ? 9 : 5;
          e.addr = ((cfg_nb[l] & (16'h3C00 | ((r / 8) * 40))) + c) % 16384;
          nm = mem_val(e.addr);
        end else if (p == 2) begin
          e.rd = 1; e.areq = (w > 80) ? 9 : 6; e.fld = 1;
          e.addr = ((cfg_pb[l] & (16'h3800 | (r % 8))) + nm * 8) % 16384;
        end else begin
          e.g = 1;
        end
      end
      if (prd) begin
        e.we = 1; e.data = mem_val(paddr);
      end
      // the write carries the previous read's column and field
      begin
        int cur_idx = e.idx, cur_fld = e.fld;
        e.idx = pcol; e.fld = pfld;
        prd = e.rd; pfld = cur_fld[0]; pcol = cur_idx; paddr = e.addr;
        if (!e.we) begin e.idx = 0; e.fld = 0; end
      end
      q.push_back(e);
    end
  endtask

  // Memory model: read data valid in the window after the strobe.
  always begin
    @(negedge clk);
    #1;
    if (mem_rd) mem_rdata = 8'(mem_val(int'(mem_addr)));
  end

  // Monitor: pops one expected item per window.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk(host_grant == e.g, tag(e.sreq), host_grant, e.g);
        chk(mem_rd == e.rd, tag(e.sreq), mem_rd, e.rd);
        chk(refresh_win == e.rf, tag(e.sreq), refresh_win, e.rf);
        chk($countones({host_grant, mem_rd, refresh_win}) == 1, "R11",
            $countones({host_grant, mem_rd, refresh_win}), 1);
        if (e.rd) chk(int'(mem_addr) == e.addr, tag(e.areq), mem_addr, e.addr);
        chk(lb_we == e.we, "R7", lb_we, e.we);
        if (e.we) begin
          chk(lb_sel_pattern == e.fld, "R7", lb_sel_pattern, e.fld);
          chk(int'(lb_col) == e.idx, "R7", lb_col, e.idx);
          chk(int'(lb_data) == e.data, "R7", lb_data, e.data);
        end
        chk(line_done == e.done, "R10", line_done, e.done);
      end
    end
  end

  initial begin
    apply_cfg(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk(host_grant == 1'b1, "R1", host_grant, 1);
    chk(mem_rd == 1'b0, "R1", mem_rd, 0);
    chk(refresh_win == 1'b0, "R1", refresh_win, 0);
    chk(lb_we == 1'b0, "R1", lb_we, 0);
    chk(line_done == 1'b0, "R1", line_done, 0);
    push_line(0, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
    for (int l = 0; l < NL; l++) begin
      for (int w = 0; w < 172; w++) begin
        @(negedge clk);
        #1;
        if (w == 80) begin
          // R9: mid-line changes must not reach this line
          refresh_mode = ~refresh_mode;
          row          = ~row;
          name_base    = ~name_base;
          patt_base    = 14'h155A;
        end
        if (w == 171 && l < NL - 1) begin
          apply_cfg(l + 1);
          push_line(l + 1, 1);
        end
      end
    end
    @(negedge clk);
    #2;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule